// File: doc/BRIEF.md
# Stepped Fibonacci Term Generator

This block walks the Fibonacci sequence one term per enabled clock. Two registers hold a pair of neighbouring terms. On every step the lower register takes the upper one, and the upper register takes their sum from a single adder of `DATA_W` bits. After a seed operation the visible term is F(0). Each later advance moves it exactly one index forward, so a user who seeds the block and then applies n advances reads F(n) at the output.

The datapath is `DATA_W` bits wide, and the true sequence soon outgrows it. A sticky flag reports the first step whose freshly computed sum needed more than `DATA_W` bits. The flag rises while the visible term is still exact. On every later step the visible term is the true term modulo 2^DATA_W and can no longer be trusted. A free-running count of advances since seeding is also brought out, so a result can be matched to its sequence index.

A synchronous `init` input seeds the pair, clears the count and clears the flag. The asynchronous active-low `rst_n` puts the block in the same state.

Top module: `fib_stepper`

## Requirements
- R1: A cycle with `init` high leaves `term` = 0, `steps` = 0 and `overflow` = 0 after the next rising clock edge.
- R2: Each cycle with `adv` high and `init` low moves `term` one index forward. After n advances from the seed, `term` equals F(n) mod 2^DATA_W, with F(0)=0, F(1)=1 and F(n)=F(n-1)+F(n-2). The first ten values are 0, 1, 1, 2, 3, 5, 8, 13, 21, 34.
- R3: A cycle with both `adv` and `init` low leaves `term`, `steps` and `overflow` unchanged.
- R4: When `init` and `adv` are high in the same cycle, `init` wins: the result is the seeded state of R1 and no step is taken.
- R5: `overflow` goes to 1 on the advance that moves `term` to F(t) where F(t+1) ≥ 2^DATA_W for the first time. On that cycle `term` still holds the exact value F(t).
- R6: Once set, `overflow` stays 1 through any mix of advance and idle cycles until `init` or `rst_n` clears it.
- R7: `steps` rises by one on each advance and wraps from 2^CNT_W − 1 to 0.
- R8: While `rst_n` is low, with no clock edge needed, `term`, `steps` and `overflow` are all 0. After `rst_n` is released, stepping starts from F(0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous seed; takes priority over `adv` |
| adv | input | 1 | Advance enable: one sequence step per cycle while high |
| term | output | DATA_W | Current term F(t), taken straight from a register |
| steps | output | CNT_W | Advances since the last seed, wrapping |
| overflow | output | 1 | Sticky flag: the datapath range has been exceeded |

## Verification
The main function is run three ways. A straight burst of ten advances from the seed confirms the index alignment. An irregular mix of advance and idle cycles shows that holding never skips or repeats a term. A long run goes past the 8-bit range, and its expected terms come from the true sequence reduced modulo 2^DATA_W. The long run separates a flag raised one step early or one step late from the correct cycle, where the term is still exact. It also shows whether the wrapped terms keep following the modular sequence. Seeding with `adv` held high checks the priority, and a 6-bit step count is driven past its wrap point.

// File: rtl/fib_pkg.sv
package fib_pkg;

  // Operation applied to the term window in a given cycle.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SEED = 2'd1,
    ACT_STEP = 2'd2
  } fib_act_e;

endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
(
  input  logic     init,
  input  logic     adv,
  output fib_act_e act
);

  // Seeding dominates advancing; otherwise advance or hold.
  always_comb begin
    if (init) begin
      act = ACT_SEED;
    end else if (adv) begin
      act = ACT_STEP;
    end else begin
      act = ACT_HOLD;
    end
  end

endmodule

// File: rtl/fib_window.sv
module fib_window
  import fib_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fib_act_e          act,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic              carry
);

  localparam logic [DATA_W-1:0] SEED_LO = '0;
  localparam logic [DATA_W-1:0] SEED_HI = DATA_W'(1);

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] lo_d;
  logic [DATA_W-1:0] hi_d;

  // A single adder forms the next term and its carry out.
  always_comb begin
    {carry, sum} = {1'b0, lo_q} + {1'b0, hi_q};
  end

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    case (act)
      ACT_SEED: begin
        lo_d = SEED_LO;
        hi_d = SEED_HI;
      end
      ACT_STEP: begin
        lo_d = hi_q;
        hi_d = sum;
      end
      default: begin
        lo_d = lo_q;
        hi_d = hi_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= SEED_LO;
      hi_q <= SEED_HI;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R2: on a step the old upper term slides into the lower slot.
  p_slide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (lo_q == $past(hi_q)));

  // R2: on a step the upper slot receives the sum modulo 2^DATA_W.
  p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (hi_q == DATA_W'($past(lo_q) + $past(hi_q))));

endmodule

// File: rtl/fib_ovf_flag.sv
module fib_ovf_flag
  import fib_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fib_act_e act,
  input  logic     carry,
  output logic     flag_q
);

  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (act == ACT_SEED) begin
      flag_d = 1'b0;
    end else if (act == ACT_STEP && carry) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  // R5: a step that loads a carried sum raises the flag.
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && carry) |=> flag_q);

  // R6: the flag is released only by a seed.
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && act != ACT_SEED) |=> flag_q);

endmodule

// File: rtl/fib_step_count.sv
module fib_step_count
  import fib_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fib_act_e         act,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (act == ACT_SEED) begin
      cnt_d = '0;
    end else if (act == ACT_STEP) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R7: each advance adds exactly one, wrapping at the counter width.
  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/fib_stepper.sv
module fib_stepper
  import fib_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              adv,
  output logic [DATA_W-1:0] term,
  output logic [CNT_W-1:0]  steps,
  output logic              overflow
);

  fib_act_e          act;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;
  logic              carry;

  fib_ctrl u_ctrl (
    .init (init),
    .adv  (adv),
    .act  (act)
  );

  fib_window #(.DATA_W(DATA_W)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .lo_q  (lo_q),
    .hi_q  (hi_q),
    .carry (carry)
  );

  fib_ovf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .carry  (carry),
    .flag_q (overflow)
  );

  fib_step_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .cnt_q (steps)
  );

  assign term = lo_q;

  // R1 and R4: a seed request, with or without adv, gives the seeded state.
  p_seed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (term == '0 && steps == '0 && !overflow));

  // R3: an idle cycle changes no visible state.
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !adv) |=> ($stable(term) && $stable(steps) && $stable(overflow)));

  // R5: until the flag rises the window never decreases.
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |-> (hi_q >= lo_q));

endmodule

// File: tb/test_fib_stepper.sv
`timescale 1ns/1ps
module test_fib_stepper;

  localparam int DW = 8;
  localparam int CW = 6;

  typedef struct {
    logic [DW-1:0] term;
    logic [CW-1:0] steps;
    logic          ovf;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init = 1'b0;
  logic          adv = 1'b0;
  logic [DW-1:0] term;
  logic [CW-1:0] steps;
  logic          overflow;

  int   n_run = 0;
  int   n_fail = 0;
  int   t_model = 0;
  int   first_big = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  fib_stepper #(.DATA_W(DW), .CNT_W(CW)) i_fib_stepper (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (init),
    .adv      (adv),
    .term     (term),
    .steps    (steps),
    .overflow (overflow)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] fib_mod(input int n);
    logic [DW-1:0] x = '0;
    logic [DW-1:0] y = DW'(1);
    logic [DW-1:0] z;
    for (int i = 0; i < n; i++) begin
      z = DW'(x + y);
      x = y;
      y = z;
    end
    return x;
  endfunction

  // Index of the first term that does not fit in DW bits.
  function automatic int find_first_big();
    longint x = 0;
    longint y = 1;
    longint z;
    int idx = 0;
    while (x < (longint'(1) << DW)) begin
      z = x + y;
      x = y;
      y = z;
      idx++;
    end
    return idx;
  endfunction

  task automatic check(input string req, input longint act_v, input longint exp_v, input string what);
    n_run++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic drive(input logic a, input logic s, input string tag);
    exp_t e;
    @(negedge clk);
    adv = a;
    init = s;
    if (s) t_model = 0;
    else if (a) t_model++;
    e.term  = fib_mod(t_model);
    e.steps = CW'(t_model);
    e.ovf   = (t_model + 1 >= first_big);
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compare outputs after each edge against the scoreboard.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(e.tag, term, e.term, "term");
        check(e.tag, steps, e.steps, "steps");
        check(e.tag, overflow, e.ovf, "overflow");
      end
    end
  end

  task automatic async_reset();
    @(negedge clk);
    adv = 1'b1;
    #3;
    rst_n = 1'b0;
    #1;
    // R8: asynchronous clear, observed before any clock edge.
    check("R8", term, 0, "term in reset");
    check("R8", steps, 0, "steps in reset");
    check("R8", overflow, 0, "overflow in reset");
    t_model = 0;
    @(negedge clk);
    adv = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    first_big = find_first_big();
    repeat (2) @(negedge clk);
    #1;
    check("R8", term, 0, "term after power-up reset");
    check("R8", overflow, 0, "overflow after power-up reset");
    rst_n = 1'b1;

    // R1: seed.
    drive(1'b0, 1'b1, "R1");
    // R2: first ten terms, straight burst.
    for (int i = 0; i < 9; i++) drive(1'b1, 1'b0, "R2");
    drive(1'b0, 1'b0, "R3");
    #1;
    @(posedge clk);
    #3;
    check("R2", term, 34, "tenth term F(9)");
    // R3: idle cycles mixed with advances.
    for (int i = 0; i < 6; i++) drive(i % 2 == 0, 1'b0, "R3");
    // R4: seed with adv held high.
    drive(1'b1, 1'b1, "R4");
    drive(1'b1, 1'b1, "R4");
    // R5: run to just before the overflowing step.
    for (int i = 0; i < first_big - 2; i++) drive(1'b1, 1'b0, "R2");
    drive(1'b0, 1'b0, "R5");
    @(posedge clk);
    #3;
    check("R5", overflow, 0, "flag one step before range exceeded");
    drive(1'b1, 1'b0, "R5");
    @(posedge clk);
    #3;
    check("R5", overflow, 1, "flag on first carried step");
    check("R5", term, fib_mod(first_big - 1), "term still exact when flag rises");
    // R6: sticky through mixed advance and idle cycles.
    for (int i = 0; i < 12; i++) drive(i % 3 != 0, 1'b0, "R6");
    // R7: run past the step counter wrap.
    for (int i = 0; i < 60; i++) drive(1'b1, 1'b0, "R7");
    // R1: seed clears the sticky flag.
    drive(1'b0, 1'b1, "R1");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, "R2");
    drive(1'b0, 1'b0, "R3");
    @(posedge clk);
    #3;
    // R8: asynchronous reset mid-run, then restart.
    async_reset();
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, "R8");
    drive(1'b0, 1'b0, "R8");
    repeat (3) @(posedge clk);
    #3;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule